// File: doc/BRIEF.md
# Per-CPU Highest-Priority Interrupt Selector

This block looks at the state of every interrupt source and decides, for one processor, which source should be served next and whether that processor's normal or fast interrupt line should be raised. Each source contributes an enable bit, a pending bit, a group bit, an 8-bit priority and a per-CPU target mask. One instance is placed per processor. The `CPU_ID` parameter tells the instance which bit of each target mask belongs to it.

Only enabled, pending sources that are routed to this processor take part. Among them, the one with the numerically smallest priority wins. The winner is then filtered twice. The priority mask decides whether the winner's ID is published. The running priority, together with the group enables, decides whether a line is asserted. A group 0 winner can be steered to the fast line.

All outputs are registered. Storage of source state, register access, acknowledge and completion sit outside this block.

Top module: `prio_pick`

## Requirements
- R1: While `rst_n` is low, `irq_o` and `fiq_o` are 0 and `pend_id_o` is 1023.
- R2: If `dist_grp_en` is 2'b00 or `cpu_grp_en` is 2'b00, both lines are low and `pend_id_o` is 1023, whatever the sources hold.
- R3: A source takes part only when its enable and pending bits are both 1. In addition, its ID must be below 32, or its target mask must have bit `CPU_ID` set. Sources below 32 ignore their target mask.
- R4: Among the sources that take part, the smallest priority value wins. When priorities are equal, the lowest ID wins.
- R5: `pend_id_o` shows the winner's ID only when the winner's priority is strictly less than `prio_mask`. Otherwise it shows 1023 and both lines stay low.
- R6: A line is raised only when the winner's priority is also strictly less than the 9-bit `run_prio`. The idle value 0x100 blocks no 8-bit priority.
- R7: A line is raised only when the winner's group is enabled in both `dist_grp_en` and `cpu_grp_en`. In both vectors, bit 0 is group 0 and bit 1 is group 1. The ID is still published when the group is disabled.
- R8: A raised line is `fiq_o` when the winner is in group 0 and `fiq_en` is 1. In every other case it is `irq_o`. The two lines are never high together.
- R9: Every output reflects its inputs one clock edge after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_en | input | NSRC | Per-source enable |
| src_pend | input | NSRC | Per-source pending |
| src_grp | input | NSRC | Per-source group (0 or 1) |
| src_tgt | input | NSRC x NCPU | Per-source CPU target mask |
| src_prio | input | NSRC x 8 | Per-source priority, lower is more urgent |
| dist_grp_en | input | 2 | Global group enables, bit 0 = group 0 |
| cpu_grp_en | input | 2 | This CPU's group enables, bit 0 = group 0 |
| prio_mask | input | 8 | Publication threshold |
| run_prio | input | 9 | Running priority, 0x100 when idle |
| fiq_en | input | 1 | Steer group 0 to the fast line |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| pend_id_o | output | 10 | Highest pending ID, 1023 when none |

## Verification
The bench builds the block with 40 sources, four CPUs and `CPU_ID` = 2. With those values, the private boundary at IDs 31 and 32 and the top source, ID 39, can both be reached. A source at ID 32 or above can be aimed at other processors and excluded because its target bit for CPU 2 is clear. The narrower source count keeps the scan short, but the private/shared split at 32 and the ties between IDs are unchanged.

// File: rtl/prio_pick_pkg.sv
package prio_pick_pkg;
    localparam int PRIO_W = 8;
    localparam int ID_W   = 10;
    localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

    typedef struct packed {
        logic            irq;
        logic            fiq;
        logic [ID_W-1:0] id;
    } pick_out_t;
endpackage

// File: rtl/prio_pick_cand.sv
module prio_pick_cand #(
    parameter int NSRC   = 64,
    parameter int NCPU   = 8,
    parameter int PRIV   = 32,
    parameter int CPU_ID = 0
) (
    input  logic [NSRC-1:0]           en,
    input  logic [NSRC-1:0]           pend,
    input  logic [NSRC-1:0][NCPU-1:0] tgt,
    output logic [NSRC-1:0]           cand
);
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        if (g < PRIV) begin : g_priv
            // private source: routing mask has no say
            assign cand[g] = en[g] & pend[g];
        end else begin : g_shared
            assign cand[g] = en[g] & pend[g] & tgt[g][CPU_ID];
        end
    end
endmodule

// File: rtl/prio_pick_scan.sv
module prio_pick_scan
    import prio_pick_pkg::*;
#(
    parameter int NSRC = 64,
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic [NSRC-1:0]             cand,
    input  logic [NSRC-1:0][PRIO_W-1:0] prio,
    output logic                        win_vld,
    output logic [IDX_W-1:0]            win_idx,
    output logic [PRIO_W-1:0]           win_prio
);
    logic [PRIO_W:0]  best_p;
    logic [IDX_W-1:0] best_i;

    always_comb begin
        best_p = {1'b1, {PRIO_W{1'b0}}};
        best_i = '0;
        for (int i = 0; i < NSRC; i++) begin
            // strict compare keeps the earlier (lower) ID on ties
            if (cand[i] && ({1'b0, prio[i]} < best_p)) begin
                best_p = {1'b0, prio[i]};
                best_i = IDX_W'(i);
            end
        end
        win_vld  = ~best_p[PRIO_W];
        win_idx  = best_i;
        win_prio = best_p[PRIO_W-1:0];
    end
endmodule

// File: rtl/prio_pick.sv
module prio_pick
    import prio_pick_pkg::*;
#(
    parameter int NSRC   = 64,
    parameter int NCPU   = 8,
    parameter int PRIV   = 32,
    parameter int CPU_ID = 0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NSRC-1:0]                src_en,
    input  logic [NSRC-1:0]                src_pend,
    input  logic [NSRC-1:0]                src_grp,
    input  logic [NSRC-1:0][NCPU-1:0]      src_tgt,
    input  logic [NSRC-1:0][PRIO_W-1:0]    src_prio,
    input  logic [1:0]                     dist_grp_en,
    input  logic [1:0]                     cpu_grp_en,
    input  logic [PRIO_W-1:0]              prio_mask,
    input  logic [PRIO_W:0]                run_prio,
    input  logic                           fiq_en,
    output logic                           irq_o,
    output logic                           fiq_o,
    output logic [ID_W-1:0]                pend_id_o
);
    localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

    logic [NSRC-1:0]   cand;
    logic              win_vld;
    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] win_prio;
    logic              win_grp;
    pick_out_t         out_d, out_q;

    prio_pick_cand #(
        .NSRC(NSRC), .NCPU(NCPU), .PRIV(PRIV), .CPU_ID(CPU_ID)
    ) cand_i (
        .en(src_en), .pend(src_pend), .tgt(src_tgt), .cand(cand)
    );

    prio_pick_scan #(.NSRC(NSRC)) scan_i (
        .cand(cand), .prio(src_prio),
        .win_vld(win_vld), .win_idx(win_idx), .win_prio(win_prio)
    );

    assign win_grp = src_grp[win_idx];

    always_comb begin
        out_d.irq = 1'b0;
        out_d.fiq = 1'b0;
        out_d.id  = ID_NONE;
        if ((|dist_grp_en) && (|cpu_grp_en) && win_vld
            && (win_prio < prio_mask)) begin
            out_d.id = ID_W'(win_idx);
            if (({1'b0, win_prio} < run_prio)
                && dist_grp_en[win_grp] && cpu_grp_en[win_grp]) begin
                if (!win_grp && fiq_en) begin
                    out_d.fiq = 1'b1;
                end else begin
                    out_d.irq = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '{irq: 1'b0, fiq: 1'b0, id: ID_NONE};
        end else begin
            out_q <= out_d;
        end
    end

    assign irq_o     = out_q.irq;
    assign fiq_o     = out_q.fiq;
    assign pend_id_o = out_q.id;
endmodule

// File: rtl/prio_pick_chk.sv
module prio_pick_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] dist_grp_en,
    input logic [1:0] cpu_grp_en,
    input logic [7:0] prio_mask,
    input logic [8:0] run_prio,
    input logic       fiq_en,
    input logic       irq_o,
    input logic       fiq_o,
    input logic [9:0] pend_id_o
);
    // R8
    lines_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_o && fiq_o));

    // R2
    master_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dist_grp_en == 2'b00 || cpu_grp_en == 2'b00)
        |=> (!irq_o && !fiq_o && pend_id_o == 10'd1023));

    // R5
    mask_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (prio_mask == 8'd0) |=> (pend_id_o == 10'd1023));

    // R5
    line_has_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o || fiq_o) |-> (pend_id_o != 10'd1023));

    // R6
    run_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_prio == 9'd0) |=> (!irq_o && !fiq_o));

    // R8
    fiq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fiq_en |=> !fiq_o);
endmodule

bind prio_pick prio_pick_chk chk_i (
    .clk(clk), .rst_n(rst_n), .dist_grp_en(dist_grp_en),
    .cpu_grp_en(cpu_grp_en), .prio_mask(prio_mask), .run_prio(run_prio),
    .fiq_en(fiq_en), .irq_o(irq_o), .fiq_o(fiq_o), .pend_id_o(pend_id_o)
);

// File: tb/prio_pick_tb.sv
`timescale 1ns/1ps
module prio_pick_tb_top;
    localparam int NSRC = 40;
    localparam int NCPU = 4;
    localparam int ME   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NSRC-1:0] src_en, src_pend, src_grp;
    logic [NSRC-1:0][NCPU-1:0] src_tgt;
    logic [NSRC-1:0][7:0] src_prio;
    logic [1:0] dist_grp_en, cpu_grp_en;
    logic [7:0] prio_mask;
    logic [8:0] run_prio;
    logic fiq_en;
    logic irq_o, fiq_o;
    logic [9:0] pend_id_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prio_pick #(.NSRC(NSRC), .NCPU(NCPU), .PRIV(32), .CPU_ID(ME)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_en(src_en), .src_pend(src_pend),
        .src_grp(src_grp), .src_tgt(src_tgt), .src_prio(src_prio),
        .dist_grp_en(dist_grp_en), .cpu_grp_en(cpu_grp_en),
        .prio_mask(prio_mask), .run_prio(run_prio), .fiq_en(fiq_en),
        .irq_o(irq_o), .fiq_o(fiq_o), .pend_id_o(pend_id_o)
    );

    typedef struct packed {
        logic [5:0] a_id; logic [7:0] a_pr; logic a_g; logic [3:0] a_t;
        logic [5:0] b_id; logic [7:0] b_pr; logic b_g; logic [3:0] b_t;
        logic [1:0] den; logic [1:0] cen; logic [7:0] msk; logic [8:0] run;
        logic fen; logic eirq; logic efiq; logic [9:0] eid; logic [3:0] req;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VT [0:NV-1] = '{
        // R4 private source 5 beats shared 36
        '{6'd5, 8'h40, 1'b1, 4'h0, 6'd36, 8'h80, 1'b1, 4'b0100, 2'd3, 2'd3, 8'hFF, 9'h100, 1'b0, 1'b1, 1'b0, 10'd5, 4'd4},
        // R3 shared source 36 routed to CPU 2 wins
        '{6'd5, 8'h90, 1'b1, 4'h0, 6'd36, 8'h80, 1'b1, 4'b0100, 2'd3, 2'd3, 8'hFF, 9'h100, 1'b0, 1'b1, 1'b0, 10'd36, 4'd3},
        // R3 source 36 routed elsewhere is excluded
        '{6'd5, 8'h90, 1'b1, 4'h0, 6'd36, 8'h80, 1'b1, 4'b1011, 2'd3, 2'd3, 8'hFF, 9'h100, 1'b0, 1'b1, 1'b0, 10'd5, 4'd3},
        // R4 tie goes to lower ID
        '{6'd10, 8'h60, 1'b1, 4'h0, 6'd7, 8'h60, 1'b1, 4'h0, 2'd3, 2'd3, 8'hFF, 9'h100, 1'b0, 1'b1, 1'b0, 10'd7, 4'd4},
        // R5 priority equal to mask is hidden
        '{6'd5, 8'h40, 1'b1, 4'h0, 6'd36, 8'h80, 1'b1, 4'h0, 2'd3, 2'd3, 8'h40, 9'h100, 1'b0, 1'b0, 1'b0, 10'd1023, 4'd5},
        // R6 priority equal to running priority: published, no line
        '{6'd5, 8'h40, 1'b1, 4'h0, 6'd36, 8'h80, 1'b1, 4'h0, 2'd3, 2'd3, 8'h41, 9'h040, 1'b0, 1'b0, 1'b0, 10'd5, 4'd6},
        // R6 just below running priority raises the line
        '{6'd5, 8'h40, 1'b1, 4'h0, 6'd36, 8'h80, 1'b1, 4'h0, 2'd3, 2'd3, 8'h41, 9'h041, 1'b0, 1'b1, 1'b0, 10'd5, 4'd6},
        // R8 group 0 with fast enable goes to fiq
        '{6'd5, 8'h40, 1'b0, 4'h0, 6'd36, 8'h80, 1'b1, 4'h0, 2'd3, 2'd3, 8'hFF, 9'h100, 1'b1, 1'b0, 1'b1, 10'd5, 4'd8},
        // R8 group 0 without fast enable goes to irq
        '{6'd5, 8'h40, 1'b0, 4'h0, 6'd36, 8'h80, 1'b1, 4'h0, 2'd3, 2'd3, 8'hFF, 9'h100, 1'b0, 1'b1, 1'b0, 10'd5, 4'd8},
        // R8 group 1 stays on irq even with fast enable
        '{6'd5, 8'h40, 1'b1, 4'h0, 6'd36, 8'h80, 1'b1, 4'h0, 2'd3, 2'd3, 8'hFF, 9'h100, 1'b1, 1'b1, 1'b0, 10'd5, 4'd8},
        // R7 group 1 disabled at the CPU
        '{6'd5, 8'h40, 1'b1, 4'h0, 6'd36, 8'h80, 1'b1, 4'h0, 2'd3, 2'd1, 8'hFF, 9'h100, 1'b0, 1'b0, 1'b0, 10'd5, 4'd7},
        // R7 group 1 disabled globally
        '{6'd5, 8'h40, 1'b1, 4'h0, 6'd36, 8'h80, 1'b1, 4'h0, 2'd1, 2'd3, 8'hFF, 9'h100, 1'b0, 1'b0, 1'b0, 10'd5, 4'd7},
        // R2 nothing enabled globally
        '{6'd5, 8'h40, 1'b1, 4'h0, 6'd36, 8'h80, 1'b1, 4'h0, 2'd0, 2'd3, 8'hFF, 9'h100, 1'b0, 1'b0, 1'b0, 10'd1023, 4'd2},
        // R2 nothing enabled at the CPU
        '{6'd5, 8'h40, 1'b1, 4'h0, 6'd36, 8'h80, 1'b1, 4'h0, 2'd3, 2'd0, 8'hFF, 9'h100, 1'b0, 1'b0, 1'b0, 10'd1023, 4'd2},
        // R7 only group 0 enabled, group 0 winner fires fiq
        '{6'd5, 8'h40, 1'b0, 4'h0, 6'd36, 8'h80, 1'b1, 4'h0, 2'd1, 2'd1, 8'hFF, 9'h100, 1'b1, 1'b0, 1'b1, 10'd5, 4'd7}
    };

    task automatic chk(input string req, input logic ei, input logic ef, input logic [9:0] eid);
        n_run++;
        if (irq_o !== ei || fiq_o !== ef || pend_id_o !== eid) begin
            n_fail++;
            $display("FAIL %s: irq/fiq/id = %0b/%0b/%0d expected %0b/%0b/%0d",
                     req, irq_o, fiq_o, pend_id_o, ei, ef, eid);
        end
    endtask

    task automatic clear_src();
        src_en = '0; src_pend = '0; src_grp = '0; src_tgt = '0; src_prio = '1;
    endtask

    task automatic add_src(input int id, input logic [7:0] p, input logic g, input logic [3:0] t);
        src_en[id] = 1'b1; src_pend[id] = 1'b1; src_grp[id] = g;
        src_prio[id] = p; src_tgt[id] = t;
    endtask

    task automatic ctl(input logic [1:0] d, input logic [1:0] c, input logic [7:0] m,
                       input logic [8:0] r, input logic f);
        dist_grp_en = d; cpu_grp_en = c; prio_mask = m; run_prio = r; fiq_en = f;
    endtask

    task automatic settle();
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        clear_src();
        add_src(3, 8'h10, 1'b1, 4'h0);
        ctl(2'd3, 2'd3, 8'hFF, 9'h100, 1'b0);
        repeat (3) @(posedge clk);
        #1;
        // R1 reset holds outputs idle despite a live source
        chk("R1", 1'b0, 1'b0, 10'd1023);
        @(negedge clk); rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            clear_src();
            add_src(VT[v].a_id, VT[v].a_pr, VT[v].a_g, VT[v].a_t);
            add_src(VT[v].b_id, VT[v].b_pr, VT[v].b_g, VT[v].b_t);
            ctl(VT[v].den, VT[v].cen, VT[v].msk, VT[v].run, VT[v].fen);
            settle();
            chk($sformatf("R%0d vec%0d", VT[v].req, v), VT[v].eirq, VT[v].efiq, VT[v].eid);
        end

        // R3 enable off: pending source ignored
        @(negedge clk); clear_src(); ctl(2'd3, 2'd3, 8'hFF, 9'h100, 1'b0);
        add_src(3, 8'h20, 1'b1, 4'h0); src_en[3] = 1'b0;
        settle(); chk("R3 disabled src", 1'b0, 1'b0, 10'd1023);
        // R3 pending off: enabled source ignored
        @(negedge clk); src_en[3] = 1'b1; src_pend[3] = 1'b0;
        settle(); chk("R3 not pending", 1'b0, 1'b0, 10'd1023);

        // R3 private boundary: ID 31 ignores mask, ID 32 needs it
        @(negedge clk); clear_src();
        add_src(31, 8'h50, 1'b1, 4'h0); add_src(32, 8'h30, 1'b1, 4'h0);
        settle(); chk("R3 id31 private", 1'b1, 1'b0, 10'd31);
        @(negedge clk); src_tgt[32] = 4'b0100;
        settle(); chk("R3 id32 routed", 1'b1, 1'b0, 10'd32);

        // R4 top ID alone, then losing a tie to ID 0
        @(negedge clk); clear_src(); add_src(39, 8'h70, 1'b1, 4'b0100);
        settle(); chk("R4 top id", 1'b1, 1'b0, 10'd39);
        @(negedge clk); add_src(0, 8'h70, 1'b1, 4'h0);
        settle(); chk("R4 tie id0", 1'b1, 1'b0, 10'd0);

        // R6 idle running priority does not block 0xFE
        @(negedge clk); clear_src(); add_src(9, 8'hFE, 1'b1, 4'h0);
        ctl(2'd3, 2'd3, 8'hFF, 9'h100, 1'b0);
        settle(); chk("R6 idle run", 1'b1, 1'b0, 10'd9);

        // R9 one-edge latency: old value before the edge, new after
        @(negedge clk); clear_src(); add_src(12, 8'h20, 1'b0, 4'h0);
        #1; chk("R9 before edge", 1'b1, 1'b0, 10'd9);
        settle(); chk("R9 after edge", 1'b1, 1'b0, 10'd12);

        // R1 reset reasserted returns outputs to idle
        @(negedge clk); rst_n = 1'b0;
        settle(); chk("R1 reassert", 1'b0, 1'b0, 10'd1023);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule